// File: doc/BRIEF.md
# Masked Interrupt Bid Generator

This block sits between the per-channel status generators of a multi-channel serial controller and the host interrupt line. Each channel presents eight status bits: transmit FIFO service, receive FIFO service, break change, a reserved position, flow-control character recognition, address recognition, receiver idle time-out and input change of state. A per-channel enable mask selects which of them may interrupt. Every status bit that is both set and enabled is a candidate, and each candidate carries a 3-bit priority.

Four source types take their priority from a programmable per-channel bid register: break change, change of state, flow-control character and address recognition. The transmit, receive and idle time-out sources use fixed priorities that are set by parameters. The arbiter picks the candidate with the highest priority. It drives the active-low request line, an arbitration number built as {priority, channel} and a source identifier built as {channel, source position}. The number and the identifier are held in registers so a host can read them as stable values.

A small register port writes and reads the mask and bid registers. The register address is {channel, register select}.

Top module: `ibg_top`

## Requirements
- R1: A status bit has no effect on `irq_n`, `win_num` or `win_id` while its enable bit in that channel's mask register is 0.
- R2: After reset `irq_n` is 1. It goes low one clock after at least one enabled status bit is pending.
- R3: Status and mask bit positions per channel are: 0 transmit service, 1 receive service, 2 break change, 3 reserved, 4 flow-control character, 5 address recognition, 6 idle time-out, 7 change of state. `win_id` equals {channel, bit position of the winner}.
- R4: Mask bit 3 always reads back as 0 and never enables a source, whatever value was written to it.
- R5: The register select (address bits 2:0) decodes as follows: 0 mask, 1 break bid, 2 change-of-state bid, 3 flow-control bid, 4 address bid. Select values 5 to 7 read as 0. Bid registers keep data bits 2:0, and bits 7:3 read as 0.
- R6: The winner is the candidate with the highest priority, and `win_num` equals {winner priority, winner channel}.
- R7: When priorities are equal, the lower channel wins. Within one channel, the higher bit position wins.
- R8: The fixed priorities default to 1 for transmit service, 2 for receive service and 3 for idle time-out.
- R9: `irq_n` returns to 1 one clock after no enabled source is pending. While `irq_n` is 1, `win_num` and `win_id` are 0.
- R10: `irq_n`, `win_num` and `win_id` change only at a clock edge after their inputs change. They stay unchanged within the cycle in which status changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel, register select} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| status_in | input | 32 | Eight status bits per channel, channel 0 in the low byte |
| irq_n | output | 1 | Active-low interrupt request |
| win_num | output | 5 | Winning arbitration number {priority, channel} |
| win_id | output | 5 | Winning source {channel, bit position} |

## Verification
The hardest cases to reach are the tie-break orders. A tie needs two candidates with identical priorities, and the bid registers of several channels must agree while their status bits overlap. The bench programs matching bids on two channels first, then on two sources of one channel, and raises both status bits in the same cycle. It then moves one bid or drops one status bit so that the expected winner changes, which shows the result comes from the tie rule and not from a fixed scan.

// File: rtl/ibg_pkg.sv
package ibg_pkg;
   localparam int SRC_N = 8;
   localparam int SRC_W = 3;

   localparam int SRC_TX  = 0;
   localparam int SRC_RX  = 1;
   localparam int SRC_BRK = 2;
   localparam int SRC_RSV = 3;
   localparam int SRC_XON = 4;
   localparam int SRC_ADR = 5;
   localparam int SRC_WDG = 6;
   localparam int SRC_COS = 7;

   typedef enum logic [2:0] {
      RS_MASK = 3'd0,
      RS_BRK  = 3'd1,
      RS_COS  = 3'd2,
      RS_XON  = 3'd3,
      RS_ADR  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/ibg_regs.sv
module ibg_regs
   import ibg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int PRIO_W = 3,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int ADDR_W = CH_W + SRC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [7:0]                 reg_wdata,
   output logic [7:0]                 reg_rdata,
   output logic [NUM_CH*SRC_N-1:0]    mask_o,
   output logic [NUM_CH*PRIO_W-1:0]   brk_o,
   output logic [NUM_CH*PRIO_W-1:0]   cos_o,
   output logic [NUM_CH*PRIO_W-1:0]   xon_o,
   output logic [NUM_CH*PRIO_W-1:0]   adr_o
);
   localparam logic [7:0] RSV_CLR = ~(8'h01 << SRC_RSV);

   logic [CH_W-1:0]  a_ch;
   logic [SRC_W-1:0] a_sel;
   logic [7:0]       rd_word [NUM_CH];

   assign a_ch  = reg_addr[ADDR_W-1:SRC_W];
   assign a_sel = reg_addr[SRC_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [7:0]        mask_r;
      logic [PRIO_W-1:0] brk_r, cos_r, xon_r, adr_r;
      logic              hit;

      assign hit = reg_we && (a_ch == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_r <= '0;
            brk_r  <= '0;
            cos_r  <= '0;
            xon_r  <= '0;
            adr_r  <= '0;
         end else if (hit) begin
            case (a_sel)
               RS_MASK: mask_r <= reg_wdata & RSV_CLR;
               RS_BRK:  brk_r  <= reg_wdata[PRIO_W-1:0];
               RS_COS:  cos_r  <= reg_wdata[PRIO_W-1:0];
               RS_XON:  xon_r  <= reg_wdata[PRIO_W-1:0];
               RS_ADR:  adr_r  <= reg_wdata[PRIO_W-1:0];
               default: ;
            endcase
         end
      end

      assign rd_word[c] = (a_sel == RS_MASK) ? mask_r      :
                          (a_sel == RS_BRK)  ? 8'(brk_r)   :
                          (a_sel == RS_COS)  ? 8'(cos_r)   :
                          (a_sel == RS_XON)  ? 8'(xon_r)   :
                          (a_sel == RS_ADR)  ? 8'(adr_r)   : 8'h00;

      assign mask_o[c*SRC_N +: SRC_N]  = mask_r;
      assign brk_o[c*PRIO_W +: PRIO_W] = brk_r;
      assign cos_o[c*PRIO_W +: PRIO_W] = cos_r;
      assign xon_o[c*PRIO_W +: PRIO_W] = xon_r;
      assign adr_o[c*PRIO_W +: PRIO_W] = adr_r;
   end

   always_comb begin
      reg_rdata = 8'h00;
      for (int c = 0; c < NUM_CH; c++) begin
         if (a_ch == CH_W'(c)) reg_rdata = rd_word[c];
      end
   end

   // R4: the reserved enable bit never reads back as set
   always_comb begin
      if (rst_n && a_sel == RS_MASK)
         a_r4_rsv_reads_zero: assert (reg_rdata[SRC_RSV] == 1'b0);
   end
endmodule

// File: rtl/ibg_chan_req.sv
module ibg_chan_req
   import ibg_pkg::*;
#(
   parameter int PRIO_W  = 3,
   parameter int FIX_TX  = 1,
   parameter int FIX_RX  = 2,
   parameter int FIX_WDG = 3
) (
   input  logic [SRC_N-1:0]        status_i,
   input  logic [SRC_N-1:0]        mask_i,
   input  logic [PRIO_W-1:0]       brk_i,
   input  logic [PRIO_W-1:0]       cos_i,
   input  logic [PRIO_W-1:0]       xon_i,
   input  logic [PRIO_W-1:0]       adr_i,
   output logic [SRC_N-1:0]        req_o,
   output logic [SRC_N*PRIO_W-1:0] prio_o
);
   for (genvar s = 0; s < SRC_N; s++) begin : g_src
      if (s == SRC_RSV) begin : g_rsv
         assign req_o[s] = 1'b0;
         assign prio_o[s*PRIO_W +: PRIO_W] = '0;
      end else begin : g_live
         assign req_o[s] = status_i[s] & mask_i[s];
         if (s == SRC_TX) begin : g_tx
            assign prio_o[s*PRIO_W +: PRIO_W] = PRIO_W'(FIX_TX);
         end else if (s == SRC_RX) begin : g_rx
            assign prio_o[s*PRIO_W +: PRIO_W] = PRIO_W'(FIX_RX);
         end else if (s == SRC_WDG) begin : g_wdg
            assign prio_o[s*PRIO_W +: PRIO_W] = PRIO_W'(FIX_WDG);
         end else if (s == SRC_BRK) begin : g_brk
            assign prio_o[s*PRIO_W +: PRIO_W] = brk_i;
         end else if (s == SRC_COS) begin : g_cos
            assign prio_o[s*PRIO_W +: PRIO_W] = cos_i;
         end else if (s == SRC_XON) begin : g_xon
            assign prio_o[s*PRIO_W +: PRIO_W] = xon_i;
         end else begin : g_adr
            assign prio_o[s*PRIO_W +: PRIO_W] = adr_i;
         end
      end
   end
endmodule

// File: rtl/ibg_arbiter.sv
module ibg_arbiter
   import ibg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int PRIO_W = 3,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int N_REQ = NUM_CH * SRC_N
) (
   input  logic [N_REQ-1:0]        req_i,
   input  logic [N_REQ*PRIO_W-1:0] prio_i,
   output logic                    any_o,
   output logic [CH_W-1:0]         ch_o,
   output logic [SRC_W-1:0]        src_o,
   output logic [PRIO_W-1:0]       prio_o
);
   // Scan order: channel ascending, then bit position descending; a later
   // candidate replaces the held one only with a strictly larger priority.
   always_comb begin
      any_o  = 1'b0;
      ch_o   = '0;
      src_o  = '0;
      prio_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         for (int s = SRC_N - 1; s >= 0; s--) begin
            if (req_i[c*SRC_N + s] &&
                (!any_o || prio_i[(c*SRC_N + s)*PRIO_W +: PRIO_W] > prio_o)) begin
               any_o  = 1'b1;
               ch_o   = CH_W'(c);
               src_o  = SRC_W'(s);
               prio_o = prio_i[(c*SRC_N + s)*PRIO_W +: PRIO_W];
            end
         end
      end
   end
endmodule

// File: rtl/ibg_top.sv
module ibg_top
   import ibg_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int PRIO_W  = 3,
   parameter int FIX_TX  = 1,
   parameter int FIX_RX  = 2,
   parameter int FIX_WDG = 3,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int ADDR_W = CH_W + SRC_W,
   localparam int NUM_W  = PRIO_W + CH_W,
   localparam int ID_W   = CH_W + SRC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [7:0]              reg_wdata,
   output logic [7:0]              reg_rdata,
   input  logic [NUM_CH*SRC_N-1:0] status_in,
   output logic                    irq_n,
   output logic [NUM_W-1:0]        win_num,
   output logic [ID_W-1:0]         win_id
);
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 7) begin : g_bad_prio
      $error("PRIO_W must lie in 1..7");
   end
   if (FIX_TX >= (1 << PRIO_W) || FIX_RX >= (1 << PRIO_W) || FIX_WDG >= (1 << PRIO_W)) begin : g_bad_fix
      $error("fixed priorities must fit in PRIO_W bits");
   end

   logic [NUM_CH*SRC_N-1:0]        mask_w;
   logic [NUM_CH*PRIO_W-1:0]       brk_w, cos_w, xon_w, adr_w;
   logic [NUM_CH*SRC_N-1:0]        req_w;
   logic [NUM_CH*SRC_N*PRIO_W-1:0] prio_w;
   logic                           any_w;
   logic [CH_W-1:0]                ch_w;
   logic [SRC_W-1:0]               src_w;
   logic [PRIO_W-1:0]              bp_w;

   ibg_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mask_o    (mask_w),
      .brk_o     (brk_w),
      .cos_o     (cos_w),
      .xon_o     (xon_w),
      .adr_o     (adr_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      ibg_chan_req #(
         .PRIO_W(PRIO_W), .FIX_TX(FIX_TX), .FIX_RX(FIX_RX), .FIX_WDG(FIX_WDG)
      ) u_req (
         .status_i (status_in[c*SRC_N +: SRC_N]),
         .mask_i   (mask_w[c*SRC_N +: SRC_N]),
         .brk_i    (brk_w[c*PRIO_W +: PRIO_W]),
         .cos_i    (cos_w[c*PRIO_W +: PRIO_W]),
         .xon_i    (xon_w[c*PRIO_W +: PRIO_W]),
         .adr_i    (adr_w[c*PRIO_W +: PRIO_W]),
         .req_o    (req_w[c*SRC_N +: SRC_N]),
         .prio_o   (prio_w[c*SRC_N*PRIO_W +: SRC_N*PRIO_W])
      );
   end

   ibg_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb (
      .req_i  (req_w),
      .prio_i (prio_w),
      .any_o  (any_w),
      .ch_o   (ch_w),
      .src_o  (src_w),
      .prio_o (bp_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n   <= 1'b1;
         win_num <= '0;
         win_id  <= '0;
      end else begin
         irq_n   <= ~any_w;
         win_num <= any_w ? {bp_w, ch_w}  : '0;
         win_id  <= any_w ? {ch_w, src_w} : '0;
      end
   end

   a_r2_low_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> $past(req_w != '0));

   a_r9_release_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_w == '0) |-> irq_n);

   a_r3_winner_not_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (win_id[SRC_W-1:0] != SRC_W'(SRC_RSV)));

   a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n |-> (win_num == '0 && win_id == '0));

   a_r6_channel_fields_agree: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (win_num[CH_W-1:0] == win_id[ID_W-1:SRC_W]));
endmodule

// File: tb/ibg_top_bench.sv
module ibg_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [31:0] status_in = '0;
   logic        irq_n;
   logic [4:0]  win_num;
   logic [4:0]  win_id;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] sh_mask [4];
   logic [2:0] sh_brk [4];
   logic [2:0] sh_cos [4];
   logic [2:0] sh_xon [4];
   logic [2:0] sh_adr [4];

   always #10 clk = ~clk;

   ibg_top u_ibg_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_in(status_in),
      .irq_n(irq_n), .win_num(win_num), .win_id(win_id)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] src_prio(input int c, input int s);
      case (s)
         0: return 3'd1;
         1: return 3'd2;
         2: return sh_brk[c];
         4: return sh_xon[c];
         5: return sh_adr[c];
         6: return 3'd3;
         7: return sh_cos[c];
         default: return 3'd0;
      endcase
   endfunction

   task automatic expect_out(input string tag);
      logic       found = 1'b0;
      logic [2:0] bp = '0;
      logic [4:0] en = '0;
      logic [4:0] ei = '0;
      for (int c = 0; c < 4; c++) begin
         for (int s = 7; s >= 0; s--) begin
            if (s != 3 && status_in[c*8+s] && sh_mask[c][s] &&
                (!found || src_prio(c, s) > bp)) begin
               found = 1'b1;
               bp = src_prio(c, s);
               en = {bp, 2'(c)};
               ei = {2'(c), 3'(s)};
            end
         end
      end
      chk({tag, " irq_n"}, 32'(irq_n), 32'(!found));
      chk({tag, " win_num"}, 32'(win_num), 32'(en));
      chk({tag, " win_id"}, 32'(win_id), 32'(ei));
   endtask

   task automatic wr(input int c, input int sel, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = {2'(c), 3'(sel)}; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         0: sh_mask[c] = d & 8'hF7;
         1: sh_brk[c] = d[2:0];
         2: sh_cos[c] = d[2:0];
         3: sh_xon[c] = d[2:0];
         4: sh_adr[c] = d[2:0];
         default: ;
      endcase
   endtask

   task automatic rd_chk(input string tag, input int c, input int sel, input logic [7:0] exp);
      @(negedge clk);
      reg_addr = {2'(c), 3'(sel)};
      #1;
      chk(tag, 32'(reg_rdata), 32'(exp));
   endtask

   // Apply status at a falling edge; results are visible after the next rising edge.
   task automatic apply(input logic [31:0] st);
      @(negedge clk);
      status_in = st;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R2 reset irq_n", 32'(irq_n), 32'd1);
      chk("R9 reset win_num", 32'(win_num), 32'd0);
      chk("R9 reset win_id", 32'(win_id), 32'd0);
      rd_chk("R5 reset mask", 1, 0, 8'h00);
   endtask

   task automatic t_masked;
      apply(32'h0000_FF00);
      expect_out("R1 all status ch1, mask 0");
      chk("R1 masked irq_n", 32'(irq_n), 32'd1);
      wr(2, 0, 8'hFF);
      apply(32'h0000_FF00);
      expect_out("R1 mask on other channel only");
      apply(32'h0);
   endtask

   task automatic t_reserved;
      wr(0, 0, 8'h08);
      rd_chk("R4 mask bit3 reads 0", 0, 0, 8'h00);
      apply(32'h0000_0008);
      chk("R4 reserved never enables", 32'(irq_n), 32'd1);
      wr(0, 0, 8'hFF);
      rd_chk("R4 full mask reads F7", 0, 0, 8'hF7);
      apply(32'h0000_0008);
      chk("R4 reserved with full mask", 32'(irq_n), 32'd1);
      apply(32'h0);
   endtask

   task automatic t_bidregs;
      wr(2, 1, 8'hFD);
      wr(2, 2, 8'h0E);
      wr(2, 3, 8'hA3);
      wr(2, 4, 8'h41);
      rd_chk("R5 break bid upper bits 0", 2, 1, 8'h05);
      rd_chk("R5 cos bid", 2, 2, 8'h06);
      rd_chk("R5 flow bid", 2, 3, 8'h03);
      rd_chk("R5 address bid", 2, 4, 8'h01);
      rd_chk("R5 unused select", 2, 6, 8'h00);
      rd_chk("R5 other channel untouched", 3, 1, 8'h00);
   endtask

   task automatic t_basic;
      wr(0, 0, 8'h01);
      @(negedge clk);
      status_in = 32'h0000_0001;
      #1;
      chk("R10 irq_n unchanged before edge", 32'(irq_n), 32'd1);
      @(negedge clk);
      chk("R2 irq low after one edge", 32'(irq_n), 32'd0);
      chk("R3 tx id", 32'(win_id), 32'h00);
      chk("R8 tx prio 1 num", 32'(win_num), 32'h04);
      expect_out("R2 single tx source");
   endtask

   task automatic t_priority;
      wr(0, 0, 8'h03);
      wr(1, 0, 8'h04);
      wr(1, 1, 8'h06);
      wr(3, 0, 8'h80);
      wr(3, 2, 8'h07);
      apply(32'h8000_0403);
      chk("R6 cos ch3 bid7 wins id", 32'(win_id), 32'h1F);
      chk("R6 cos ch3 bid7 wins num", 32'(win_num), 32'h1F);
      expect_out("R6 three channels");
      apply(32'h0000_0403);
      chk("R6 break ch1 bid6 id", 32'(win_id), 32'h0A);
      chk("R6 break ch1 bid6 num", 32'(win_num), 32'h19);
      wr(1, 1, 8'h00);
      apply(32'h0000_0403);
      chk("R6 lowered break bid lets rx win", 32'(win_id), 32'h01);
      expect_out("R6 reprogrammed bid");
      apply(32'h0);
   endtask

   task automatic t_tie;
      wr(1, 0, 8'h10);
      wr(2, 0, 8'h10);
      wr(1, 3, 8'h04);
      wr(2, 3, 8'h04);
      apply(32'h0010_1000);
      chk("R7 equal bids lower channel", 32'(win_id), 32'h0C);
      expect_out("R7 channel tie");
      wr(2, 3, 8'h05);
      apply(32'h0010_1000);
      chk("R7 raised bid ch2 now wins", 32'(win_id), 32'h14);
      wr(0, 0, 8'h30);
      wr(0, 3, 8'h07);
      wr(0, 4, 8'h07);
      apply(32'h0000_0030);
      chk("R7 same channel higher position", 32'(win_id), 32'h05);
      expect_out("R7 source tie");
      apply(32'h0000_0010);
      chk("R7 only flow source left", 32'(win_id), 32'h04);
      apply(32'h0);
   endtask

   task automatic t_fixed;
      wr(0, 0, 8'h43);
      apply(32'h0000_0043);
      chk("R8 idle timeout prio 3 wins", 32'(win_num), 32'h0C);
      chk("R3 idle timeout position 6", 32'(win_id), 32'h06);
      apply(32'h0000_0003);
      chk("R8 rx prio 2 beats tx", 32'(win_num), 32'h08);
      chk("R3 rx position 1", 32'(win_id), 32'h01);
      expect_out("R8 fixed types");
   endtask

   task automatic t_release;
      @(negedge clk);
      status_in = 32'h0;
      #1;
      chk("R10 irq held before edge", 32'(irq_n), 32'd0);
      @(negedge clk);
      chk("R9 irq released", 32'(irq_n), 32'd1);
      chk("R9 num cleared", 32'(win_num), 32'd0);
      chk("R9 id cleared", 32'(win_id), 32'd0);
      wr(0, 0, 8'h00);
      apply(32'hFFFF_FFFF);
      expect_out("R9 masked off after service");
      apply(32'h0);
   endtask

   task automatic report;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 4; c++) begin
         sh_mask[c] = '0; sh_brk[c] = '0; sh_cos[c] = '0; sh_xon[c] = '0; sh_adr[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masked();
      t_reserved();
      t_bidregs();
      t_basic();
      t_priority();
      t_tie();
      t_fixed();
      t_release();
      done = 1'b1;
      report();
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         report();
      end
   end
endmodule